// File: doc/BRIEF.md
# Link Pause Request Controller

This block decides when the transmit MAC should emit a link-level pause frame and which 16-bit pause quanta that frame carries. It hands each decision to a downstream frame generator over a request/acknowledge pair. The generator builds the frame, computes its check sequence and arbitrates it against data traffic. This block only gates the request and times the gap between XOFF requests.

Requests come from one of two sources, chosen by a source-select field. The first is a level input: asserting it asks the link partner to stop (XOFF), and deasserting it asks the partner to resume (XON). The second is a self-clearing trigger field in a small register file. XON always carries zero quanta. XOFF carries the programmed quanta value. After an XOFF has been acknowledged, a holdoff timer counts down in pause-quanta units of 512 bit times. That is 8 clock cycles on the assumed 64-bit datapath. Any further XOFF is delayed until the timer expires.

Top module: `pause_req_ctrl`

## Requirements
- R1: After reset, `pause_req` is low and the registers read as follows: trigger 0, quanta 0, holdoff 1, enable word 1 (enabled, level-input source).
- R2: The register file has four words. Address 0 is the trigger field in bits 1:0. Address 1 is the pause quanta in bits 15:0. Address 2 is the holdoff in bits 15:0. Address 3 holds the enable in bit 0 and the source select in bits 2:1. Unused bits read as zero.
- R3: With the register source selected, trigger code 2'b10 requests XOFF carrying the quanta register, and code 2'b01 requests XON carrying 0. Codes 2'b00 and 2'b11 do nothing. The trigger field always reads back 0.
- R4: An XOFF whose quanta register is 0 goes out as an XON: it carries quanta 0 and starts no holdoff.
- R5: With the level-input source selected, a rising edge on `pause_vec` requests XOFF and a falling edge requests XON.
- R6: Source select 2'b00 accepts only the level input, 2'b01 accepts only the trigger field, and 2'b10 or 2'b11 accept neither.
- R7: `pause_req` stays high with a stable `pause_quanta` until `pause_ack` is seen. `pause_ack` has no effect while `pause_req` is low.
- R8: `pause_req` falls on the acknowledging edge. A request made while another is outstanding is held pending, and the most recent request replaces an older pending one.
- R9: While the enable bit is 0, requests are discarded and none is issued. While `tx_path_en` is low, a pending request is held and is issued once `tx_path_en` rises.
- R10: After an XOFF with non-zero quanta is acknowledged with holdoff H, a pending XOFF raises `pause_req` exactly 8*H+1 clock edges after the acknowledging edge. With H=0 this is the next edge.
- R11: XON requests are never delayed by a running holdoff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| pause_vec | input | 1 | Level pause input: rise requests XOFF, fall requests XON |
| tx_path_en | input | 1 | Transmit path enabled |
| pause_req | output | 1 | Pause frame request to the frame generator |
| pause_quanta | output | 16 | Quanta for the requested frame, 0 for XON |
| pause_ack | input | 1 | Frame generator accepts the request |

## Verification
The bench sweeps the holdoff value and measures, to the clock edge, when a pending XOFF is issued after an acknowledge. An off-by-one in the quanta divider or in the counter reload would shift that edge by one cycle or by one full quanta. It checks that an XOFF with zero quanta, and an XON queued during a running holdoff, both go out on the very next edge. A design that loaded the timer for them would hold them back for many cycles. The reserved trigger and source codes, the deselected source, the cleared enable bit and an idle acknowledge are each driven and shown to leave `pause_req` low. A design that decoded reserved codes loosely would raise a spurious request.

// File: rtl/pause_req_pkg.sv
package pause_req_pkg;
  localparam int unsigned QW = 16;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 2;

  localparam logic [AW-1:0] ADDR_TRIG    = 2'd0;
  localparam logic [AW-1:0] ADDR_QUANTA  = 2'd1;
  localparam logic [AW-1:0] ADDR_HOLDOFF = 2'd2;
  localparam logic [AW-1:0] ADDR_ENABLE  = 2'd3;

  localparam logic [1:0] TRIG_XON  = 2'b01;
  localparam logic [1:0] TRIG_XOFF = 2'b10;
  localparam logic [1:0] SRC_VEC   = 2'b00;
  localparam logic [1:0] SRC_REG   = 2'b01;

  typedef enum logic {PK_XON = 1'b0, PK_XOFF = 1'b1} pause_kind_e;

  // XOFF with a zero quanta register is an XON in every respect
  function automatic logic is_real_xoff(pause_kind_e k, logic [QW-1:0] q);
    return (k == PK_XOFF) && (q != '0);
  endfunction

  function automatic logic [QW-1:0] frame_quanta(pause_kind_e k, logic [QW-1:0] q);
    return is_real_xoff(k, q) ? q : '0;
  endfunction
endpackage

// File: rtl/pause_cfg_regs.sv
module pause_cfg_regs
  import pause_req_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [QW-1:0] quanta_q,
  output logic [QW-1:0] holdoff_q,
  output logic          glob_en_q,
  output logic [1:0]    src_sel_q,
  output logic          trig_xon,
  output logic          trig_xoff
);
  logic trig_wr;
  assign trig_wr   = wr_en && (addr == ADDR_TRIG);
  assign trig_xon  = trig_wr && (wdata[1:0] == TRIG_XON);
  assign trig_xoff = trig_wr && (wdata[1:0] == TRIG_XOFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quanta_q  <= '0;
      holdoff_q <= QW'(1);
      glob_en_q <= 1'b1;
      src_sel_q <= SRC_VEC;
    end else if (wr_en) begin
      case (addr)
        ADDR_QUANTA:  quanta_q  <= wdata[QW-1:0];
        ADDR_HOLDOFF: holdoff_q <= wdata[QW-1:0];
        ADDR_ENABLE: begin
          glob_en_q <= wdata[0];
          src_sel_q <= wdata[2:1];
        end
        default: ;
      endcase
    end
  end

  // trigger field self-clears, so it never reads back non-zero
  always_comb begin
    case (addr)
      ADDR_QUANTA:  rdata = {{(DW-QW){1'b0}}, quanta_q};
      ADDR_HOLDOFF: rdata = {{(DW-QW){1'b0}}, holdoff_q};
      ADDR_ENABLE:  rdata = {{(DW-3){1'b0}}, src_sel_q, glob_en_q};
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/pause_holdoff_timer.sv
module pause_holdoff_timer #(
  parameter int unsigned QW  = 16,
  parameter int unsigned CPQ = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [QW-1:0] load_val,
  output logic          busy,
  output logic          tick
);
  localparam int unsigned DIVW = (CPQ > 1) ? $clog2(CPQ) : 1;
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(CPQ - 1);

  logic [QW-1:0]   cnt_q;
  logic [DIVW-1:0] div_q;

  assign busy = (cnt_q != '0);
  assign tick = busy && (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
      div_q <= '0;
    end else if (busy) begin
      if (tick) begin
        cnt_q <= cnt_q - QW'(1);
        div_q <= '0;
      end else begin
        div_q <= div_q + DIVW'(1);
      end
    end
  end
endmodule

// File: rtl/pause_req_ctrl.sv
module pause_req_ctrl
  import pause_req_pkg::*;
#(
  parameter int unsigned CYCLES_PER_QUANTA = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          pause_vec,
  input  logic          tx_path_en,
  output logic          pause_req,
  output logic [QW-1:0] pause_quanta,
  input  logic          pause_ack
);
  logic [QW-1:0] quanta_reg, holdoff_reg;
  logic          glob_en_q;
  logic [1:0]    src_sel_q;
  logic          trig_xon, trig_xoff;

  pause_cfg_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .quanta_q(quanta_reg),
    .holdoff_q(holdoff_reg), .glob_en_q(glob_en_q), .src_sel_q(src_sel_q),
    .trig_xon(trig_xon), .trig_xoff(trig_xoff)
  );

  // named internal events
  logic        vec_q, vec_rise, vec_fall;
  logic        src_vec_ok, src_reg_ok;
  logic        new_xon, new_xoff;
  logic        pend_valid;
  pause_kind_e pend_kind;
  logic        req_q;
  logic [QW-1:0] quanta_q;
  logic        issue_xoff, issue_ok, ack_evt, holdoff_load;
  logic        holdoff_busy, holdoff_tick;

  assign vec_rise   = pause_vec && !vec_q;
  assign vec_fall   = !pause_vec && vec_q;
  assign src_vec_ok = glob_en_q && (src_sel_q == SRC_VEC);
  assign src_reg_ok = glob_en_q && (src_sel_q == SRC_REG);
  assign new_xoff   = (src_vec_ok && vec_rise) || (src_reg_ok && trig_xoff);
  assign new_xon    = (src_vec_ok && vec_fall) || (src_reg_ok && trig_xon);

  assign issue_xoff   = is_real_xoff(pend_kind, quanta_reg);
  assign issue_ok     = pend_valid && !req_q && glob_en_q && tx_path_en &&
                        (!issue_xoff || !holdoff_busy);
  assign ack_evt      = req_q && pause_ack;
  assign holdoff_load = ack_evt && (quanta_q != '0);

  pause_holdoff_timer #(.QW(QW), .CPQ(CYCLES_PER_QUANTA)) hold_i (
    .clk(clk), .rst_n(rst_n), .load(holdoff_load), .load_val(holdoff_reg),
    .busy(holdoff_busy), .tick(holdoff_tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) vec_q <= 1'b0;
    else        vec_q <= pause_vec;
  end

  // pending slot: newest request wins, cleared when disabled or issued
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_kind  <= PK_XON;
    end else if (!glob_en_q) begin
      pend_valid <= 1'b0;
    end else if (new_xoff || new_xon) begin
      pend_valid <= 1'b1;
      pend_kind  <= new_xoff ? PK_XOFF : PK_XON;
    end else if (issue_ok) begin
      pend_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      quanta_q <= '0;
    end else if (issue_ok) begin
      req_q    <= 1'b1;
      quanta_q <= frame_quanta(pend_kind, quanta_reg);
    end else if (ack_evt) begin
      req_q    <= 1'b0;
    end
  end

  assign pause_req    = req_q;
  assign pause_quanta = quanta_q;
endmodule

// File: rtl/pause_req_ctrl_chk.sv
module pause_req_ctrl_chk #(
  parameter int unsigned QW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pause_req,
  input logic          pause_ack,
  input logic [QW-1:0] pause_quanta,
  input logic          tx_path_en,
  input logic          glob_en,
  input logic          holdoff_busy,
  input logic [QW-1:0] quanta_reg
);
  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req && !pause_ack |=> pause_req && $stable(pause_quanta));

  a_r8_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req && pause_ack |=> !pause_req);

  a_r9_issue_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) |-> $past(tx_path_en) && $past(glob_en));

  a_r10_holdoff_respected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) && (pause_quanta != '0) |-> !$past(holdoff_busy));

  a_r3_xoff_carries_reg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) && (pause_quanta != '0) |-> pause_quanta == $past(quanta_reg));
endmodule

bind pause_req_ctrl pause_req_ctrl_chk #(.QW(pause_req_pkg::QW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pause_req(pause_req), .pause_ack(pause_ack),
  .pause_quanta(pause_quanta), .tx_path_en(tx_path_en), .glob_en(glob_en_q),
  .holdoff_busy(holdoff_busy), .quanta_reg(quanta_reg)
);

// File: tb/pause_req_ctrl_tb_top.sv
module pause_req_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pause_vec = 1'b0;
  logic        tx_path_en = 1'b1;
  logic        pause_req;
  logic [15:0] pause_quanta;
  logic        pause_ack = 1'b0;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;
  localparam int CPQ = 8;

  always #2 clk = ~clk;

  pause_req_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pause_vec(pause_vec),
    .tx_path_en(tx_path_en), .pause_req(pause_req), .pause_quanta(pause_quanta),
    .pause_ack(pause_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_req(input string tag, input int maxc);
    int n = 0;
    while (!pause_req && n < maxc) begin
      @(negedge clk); n++;
    end
    chk(tag, {31'b0, pause_req}, 32'd1);
  endtask

  task automatic expect_idle(input string tag, input int cyc);
    logic seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pause_req) seen = 1'b1;
    end
    chk(tag, {31'b0, seen}, 32'd0);
  endtask

  task automatic do_ack();
    @(negedge clk); pause_ack = 1'b1;
    @(negedge clk); pause_ack = 1'b0;
  endtask

  // acknowledges the outstanding request, returns edges until the next rise
  task automatic ack_and_measure(output int n);
    @(negedge clk); pause_ack = 1'b1;
    @(posedge clk);
    @(negedge clk); pause_ack = 1'b0;
    n = 0;
    while (!pause_req && n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 req", {31'b0, pause_req}, 0);
    rd(2'd0, d); chk("R1 trig", d, 0);
    rd(2'd1, d); chk("R1 quanta", d, 0);
    rd(2'd2, d); chk("R1 holdoff", d, 1);
    rd(2'd3, d); chk("R1 enable", d, 1);

    // R2 register map
    wr(2'd1, 32'hFFFF_BEEF); rd(2'd1, d); chk("R2 quanta", d, 32'hBEEF);
    wr(2'd2, 32'h0001_0003); rd(2'd2, d); chk("R2 holdoff", d, 3);
    wr(2'd3, 32'hFFFF_FFFB); rd(2'd3, d); chk("R2 enable", d, 3);
    wr(2'd2, 0);

    // R3 XOFF from register trigger, R7 hold
    wr(2'd0, 2);
    rd(2'd0, d); chk("R3 trig self-clear", d, 0);
    wait_req("R3 xoff req", 10);
    chk("R3 xoff quanta", pause_quanta, 32'hBEEF);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 held", {15'b0, pause_req, pause_quanta}, {15'b0, 1'b1, 16'hBEEF});
    end
    do_ack();
    chk("R8 drop on ack", {31'b0, pause_req}, 0);
    do_ack();
    expect_idle("R7 idle ack ignored", 6);

    // R3 XON
    wr(2'd0, 1);
    wait_req("R3 xon req", 10);
    chk("R3 xon quanta", pause_quanta, 0);
    do_ack();
    // R3 no-op codes
    wr(2'd0, 0);
    wr(2'd0, 3);
    expect_idle("R3 codes 00/11 no-op", 12);

    // R4 zero quanta XOFF is XON, no holdoff
    wr(2'd1, 0); wr(2'd2, 5);
    wr(2'd0, 2);
    wait_req("R4 req", 10);
    chk("R4 quanta", pause_quanta, 0);
    wr(2'd0, 2);
    ack_and_measure(n);
    chk("R4 no holdoff", n, 1);
    do_ack();
    wr(2'd1, 32'hBEEF); wr(2'd2, 0);

    // R6 level input ignored with register source
    @(negedge clk) pause_vec = 1'b1;
    expect_idle("R6 vec ignored rise", 10);
    @(negedge clk) pause_vec = 1'b0;
    expect_idle("R6 vec ignored fall", 10);

    // R5 level input source
    wr(2'd3, 1);
    @(negedge clk) pause_vec = 1'b1;
    wait_req("R5 rise req", 10);
    chk("R5 rise quanta", pause_quanta, 32'hBEEF);
    do_ack();
    @(negedge clk) pause_vec = 1'b0;
    wait_req("R5 fall req", 10);
    chk("R5 fall quanta", pause_quanta, 0);
    do_ack();
    wr(2'd0, 2);
    expect_idle("R6 trig ignored with vec source", 10);

    // R6 reserved source
    wr(2'd3, 5);
    @(negedge clk) pause_vec = 1'b1;
    wr(2'd0, 2);
    @(negedge clk) pause_vec = 1'b0;
    wr(2'd0, 1);
    expect_idle("R6 reserved source", 12);

    // R9 global enable off
    wr(2'd3, 2);
    wr(2'd0, 2);
    wr(2'd3, 3);
    expect_idle("R9 disabled discards", 12);
    // R9 tx path hold
    @(negedge clk) tx_path_en = 1'b0;
    wr(2'd0, 2);
    expect_idle("R9 tx off holds", 12);
    @(negedge clk) tx_path_en = 1'b1;
    wait_req("R9 tx on issues", 5);
    chk("R9 quanta", pause_quanta, 32'hBEEF);
    do_ack();
    // R9 disable while pending
    @(negedge clk) tx_path_en = 1'b0;
    wr(2'd0, 2);
    wr(2'd3, 2);
    wr(2'd3, 3);
    @(negedge clk) tx_path_en = 1'b1;
    expect_idle("R9 disable clears pending", 12);

    // R10 holdoff sweep
    for (int h = 0; h < 5; h++) begin
      wr(2'd2, h);
      wr(2'd1, 32'h0100 + h);
      wr(2'd0, 2);
      wait_req("R10 first xoff", 300);
      wr(2'd0, 2);
      ack_and_measure(n);
      chk($sformatf("R10 gap h=%0d", h), n, CPQ * h + 1);
      chk("R10 quanta", pause_quanta, 32'h0100 + h);
      do_ack();
    end

    // R11 XON not held back, R8 newest pending wins
    wr(2'd2, 4);
    wr(2'd0, 2);
    wait_req("R11 xoff", 300);
    wr(2'd0, 2);
    wr(2'd0, 1);
    ack_and_measure(n);
    chk("R11 xon immediate", n, 1);
    chk("R8 newest wins quanta", pause_quanta, 0);
    do_ack();

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule